// File: doc/BRIEF.md
# Prioritized Interrupt Masking Controller

This block keeps two vector sets of 256 entries each: one holds interrupt requests that are waiting, and one holds requests that are being serviced. Each set is stored as four 64-bit words. A request enters the pending set in one of two ways. A single-vector post names one vector. A batch post ORs a full 256-bit word group into the set. The in-service set is replaced as a whole through a load port. Acknowledge and end-of-interrupt sequencing belong to the surrounding logic and drive that port.

On every cycle the block looks for the top vector in each set. Vector 2 (non-maskable) wins first and vector 0 (external) wins second. Otherwise the highest-numbered set bit wins. Vectors are grouped into classes of 16. The block combines the two top vectors with a task-priority register and classifies the top pending request as deliverable, masked by task priority, or masked by in-service. It also gives a 6-bit class hint and flags a top pending vector that falls in the reserved range.

All results are registered. They reflect the register contents of the previous cycle, so a post or a write shows at the outputs two rising edges after it is presented.

Top module: `irq_prio_mask`

## Requirements
- R1: A single-vector post with `post_vld` high and `post_vec` below 256 sets bit `post_vec[5:0]` of pending word `post_vec[7:6]`.
- R2: A post whose `post_vec` has any bit above bit 7 set is ignored. The pending set is unchanged.
- R3: A batch post ORs `batch_bits` into the pending set. A batch post and a single-vector post in the same cycle both take effect. Pending bits are never cleared except by reset.
- R4: The top pending vector is chosen in this order: vector 2 if set, then vector 0 if set, then the highest set bit. `pend_vld` is 0 when the set is empty.
- R5: `svc_ld` replaces the in-service set with `svc_bits`. Its top vector is chosen by the same rule as R4 and is shown on `svc_vec`/`svc_vld`.
- R6: The decision code is 0 = deliverable, 1 = masked by task priority, 2 = masked by in-service. The rules below apply in order and the first that matches decides. If the in-service top is vector 2, the code is 2. If the pending top is vector 2, the code is 0. If the in-service top is vector 0, the code is 2. If the pending top is vector 0, the code is 1 when mask-all is set and 0 otherwise.
- R7: For any other pending top P, let class be vector/16. P outranks the in-service top when nothing is in service or when class(P) is greater than the in-service class. An outranking P gets code 0 if mask-all is clear and class(P) is greater than the task-priority class field. Otherwise it gets code 1. A P that does not outrank gets code 2.
- R8: `hint` is 0 when nothing is pending, 32 for vector 2, 16 for vector 0, and vector/16 for any other vector.
- R9: `pend_invalid` is 1 exactly when the top pending vector is 1 or lies in 3..14.
- R10: Synchronous reset clears both sets and loads the task-priority register with 0x10000. Mask-all is bit 16 and the class field is bits 7:4, so after reset every vector except 2 is masked by task priority.
- R11: The outputs are registered and follow the register state one cycle later. When nothing is pending, `decision` and `hint` read 0.
- R12: `tpr_wr` writes `tpr_data` into the task-priority register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Single-vector post strobe |
| post_vec | input | 16 | Vector to post; values of 256 and above are rejected |
| batch_vld | input | 1 | Batch post strobe |
| batch_bits | input | 256 | Bits ORed into the pending set |
| svc_ld | input | 1 | In-service set load strobe |
| svc_bits | input | 256 | New in-service set contents |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | 17 | Task-priority value (bit 16 mask-all, bits 7:4 class) |
| pend_vld | output | 1 | Some vector is pending |
| pend_vec | output | 8 | Top pending vector |
| svc_vld | output | 1 | Some vector is in service |
| svc_vec | output | 8 | Top in-service vector |
| decision | output | 2 | 0 deliverable, 1 masked by task priority, 2 masked by in-service |
| hint | output | 6 | Priority-class hint |
| pend_invalid | output | 1 | Top pending vector is reserved |

## Verification
A single-vector post and a batch post can land in the same cycle and both write the pending words. The bench provokes this with directed pairs in which the posted vector falls in a word the batch also touches, and with random pairs. It judges the result by the top vector that emerges: the batch may carry the higher bit, or the single post may carry vector 2 or 0 and win by precedence. The in-service load can also coincide with a post, and the decision code is then checked against both new sets.

// File: rtl/irq_pm_pkg.sv
package irq_pm_pkg;
  typedef enum logic [1:0] {
    DEC_DELIVER  = 2'd0,
    DEC_TPR_MASK = 2'd1,
    DEC_SVC_MASK = 2'd2
  } dec_e;

  localparam int unsigned VEC_NMI  = 2;
  localparam int unsigned VEC_EXT  = 0;
  localparam int unsigned HINT_W   = 6;
  localparam int unsigned CLS_SH   = 4;   // vectors per class = 2**CLS_SH
  localparam logic [HINT_W-1:0] HINT_NMI = 6'd32;
  localparam logic [HINT_W-1:0] HINT_EXT = 6'd16;
endpackage

// File: rtl/irq_vec_store.sv
module irq_vec_store #(
  parameter int WORD_W   = 64,
  parameter int NWORDS   = 4,
  parameter int VEC_IN_W = 16,
  localparam int NVEC    = WORD_W * NWORDS,
  localparam int VEC_W   = $clog2(NVEC),
  localparam int WIDX_W  = $clog2(WORD_W),
  localparam int WSEL_W  = VEC_W - WIDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_vld,
  input  logic [VEC_IN_W-1:0] set_vec,
  input  logic                or_vld,
  input  logic [NVEC-1:0]     or_bits,
  input  logic                ld_vld,
  input  logic [NVEC-1:0]     ld_bits,
  output logic [NVEC-1:0]     q
);
  logic set_ok;
  assign set_ok = set_vld && (set_vec[VEC_IN_W-1:VEC_W] == '0);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q, base_w, set_w, or_w;
    assign base_w = ld_vld ? ld_bits[w*WORD_W +: WORD_W] : word_q;
    assign or_w   = or_vld ? or_bits[w*WORD_W +: WORD_W] : '0;
    assign set_w  = (set_ok && set_vec[VEC_W-1:WIDX_W] == WSEL_W'(w))
                    ? ({{(WORD_W-1){1'b0}}, 1'b1} << set_vec[WIDX_W-1:0]) : '0;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= base_w | set_w | or_w;
    end
    assign q[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/irq_top_search.sv
module irq_top_search
  import irq_pm_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int NWORDS  = 4,
  localparam int NVEC   = WORD_W * NWORDS,
  localparam int VEC_W  = $clog2(NVEC),
  localparam int WIDX_W = $clog2(WORD_W),
  localparam int WSEL_W = VEC_W - WIDX_W
) (
  input  logic [NVEC-1:0]  bits,
  output logic             found,
  output logic [VEC_W-1:0] vec
);
  logic [NWORDS-1:0]        w_any;
  logic [NWORDS*WIDX_W-1:0] w_idx;

  for (genvar w = 0; w < NWORDS; w++) begin : g_w
    logic [WIDX_W-1:0] idx;
    always_comb begin
      idx = '0;
      for (int i = 0; i < WORD_W; i++)
        if (bits[w*WORD_W + i]) idx = WIDX_W'(i);
    end
    assign w_any[w]                    = |bits[w*WORD_W +: WORD_W];
    assign w_idx[w*WIDX_W +: WIDX_W]   = idx;
  end

  always_comb begin
    found = |w_any;
    vec   = '0;
    for (int w = 0; w < NWORDS; w++)
      if (w_any[w]) vec = {WSEL_W'(w), w_idx[w*WIDX_W +: WIDX_W]};
    if (bits[VEC_NMI])      vec = VEC_W'(VEC_NMI);
    else if (bits[VEC_EXT]) vec = VEC_W'(VEC_EXT);
  end
endmodule

// File: rtl/irq_mask_judge.sv
module irq_mask_judge
  import irq_pm_pkg::*;
#(
  parameter int VEC_W  = 8,
  localparam int CLS_W = VEC_W - CLS_SH
) (
  input  logic              p_found,
  input  logic [VEC_W-1:0]  p_vec,
  input  logic              s_found,
  input  logic [VEC_W-1:0]  s_vec,
  input  logic              mask_all,
  input  logic [CLS_W-1:0]  tpr_cls,
  output dec_e              dec,
  output logic [HINT_W-1:0] hint,
  output logic              invalid
);
  logic [CLS_W-1:0] p_cls, s_cls;
  logic             outranks;
  assign p_cls    = p_vec[VEC_W-1:CLS_SH];
  assign s_cls    = s_vec[VEC_W-1:CLS_SH];
  assign outranks = p_found && (!s_found || (p_cls > s_cls));

  always_comb begin
    if (!p_found)                              dec = DEC_DELIVER;
    else if (s_found && s_vec == VEC_W'(VEC_NMI)) dec = DEC_SVC_MASK;
    else if (p_vec == VEC_W'(VEC_NMI))         dec = DEC_DELIVER;
    else if (s_found && s_vec == VEC_W'(VEC_EXT)) dec = DEC_SVC_MASK;
    else if (p_vec == VEC_W'(VEC_EXT))         dec = mask_all ? DEC_TPR_MASK : DEC_DELIVER;
    else if (outranks)                         dec = (!mask_all && p_cls > tpr_cls) ? DEC_DELIVER : DEC_TPR_MASK;
    else                                       dec = DEC_SVC_MASK;
  end

  always_comb begin
    if (!p_found)                      hint = '0;
    else if (p_vec == VEC_W'(VEC_NMI)) hint = HINT_NMI;
    else if (p_vec == VEC_W'(VEC_EXT)) hint = HINT_EXT;
    else                               hint = HINT_W'(p_cls);
  end

  assign invalid = p_found && (p_vec == VEC_W'(1) ||
                   (p_vec >= VEC_W'(3) && p_vec <= VEC_W'(14)));
endmodule

// File: rtl/irq_prio_mask.sv
module irq_prio_mask
  import irq_pm_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int NWORDS   = 4,
  parameter int VEC_IN_W = 16,
  parameter int TPR_W    = 17,
  parameter int MASK_BIT = 16,
  parameter int CLS_LSB  = 4,
  parameter logic [TPR_W-1:0] TPR_RST = 17'h10000,
  localparam int NVEC    = WORD_W * NWORDS,
  localparam int VEC_W   = $clog2(NVEC),
  localparam int CLS_W   = VEC_W - CLS_SH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                post_vld,
  input  logic [VEC_IN_W-1:0] post_vec,
  input  logic                batch_vld,
  input  logic [NVEC-1:0]     batch_bits,
  input  logic                svc_ld,
  input  logic [NVEC-1:0]     svc_bits,
  input  logic                tpr_wr,
  input  logic [TPR_W-1:0]    tpr_data,
  output logic                pend_vld,
  output logic [VEC_W-1:0]    pend_vec,
  output logic                svc_vld,
  output logic [VEC_W-1:0]    svc_vec,
  output logic [1:0]          decision,
  output logic [HINT_W-1:0]   hint,
  output logic                pend_invalid
);
  logic [NVEC-1:0]   pend_bits, svc_set;
  logic [TPR_W-1:0]  tpr_q;
  logic              p_found, s_found, inv_c;
  logic [VEC_W-1:0]  p_vec, s_vec;
  logic [HINT_W-1:0] hint_c;
  dec_e              dec_c;

  always_ff @(posedge clk) begin
    if (rst)         tpr_q <= TPR_RST;
    else if (tpr_wr) tpr_q <= tpr_data;
  end

  irq_vec_store #(.WORD_W(WORD_W), .NWORDS(NWORDS), .VEC_IN_W(VEC_IN_W)) u_pend (
    .clk(clk), .rst(rst),
    .set_vld(post_vld), .set_vec(post_vec),
    .or_vld(batch_vld), .or_bits(batch_bits),
    .ld_vld(1'b0), .ld_bits('0),
    .q(pend_bits));

  irq_vec_store #(.WORD_W(WORD_W), .NWORDS(NWORDS), .VEC_IN_W(VEC_IN_W)) u_svc (
    .clk(clk), .rst(rst),
    .set_vld(1'b0), .set_vec('0),
    .or_vld(1'b0), .or_bits('0),
    .ld_vld(svc_ld), .ld_bits(svc_bits),
    .q(svc_set));

  irq_top_search #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_pend_top (
    .bits(pend_bits), .found(p_found), .vec(p_vec));
  irq_top_search #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_svc_top (
    .bits(svc_set), .found(s_found), .vec(s_vec));

  irq_mask_judge #(.VEC_W(VEC_W)) u_judge (
    .p_found(p_found), .p_vec(p_vec), .s_found(s_found), .s_vec(s_vec),
    .mask_all(tpr_q[MASK_BIT]), .tpr_cls(tpr_q[CLS_LSB +: CLS_W]),
    .dec(dec_c), .hint(hint_c), .invalid(inv_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0; pend_vec <= '0; svc_vld <= 1'b0; svc_vec <= '0;
      decision <= '0; hint <= '0; pend_invalid <= 1'b0;
    end else begin
      pend_vld <= p_found; pend_vec <= p_vec;
      svc_vld  <= s_found; svc_vec  <= s_vec;
      decision <= dec_c;   hint     <= hint_c;
      pend_invalid <= inv_c;
    end
  end
endmodule

// File: rtl/irq_prio_mask_chk.sv
module irq_prio_mask_chk #(
  parameter int VEC_IN_W = 16,
  parameter int NVEC     = 256,
  parameter int VEC_W    = 8,
  parameter int TPR_W    = 17,
  parameter logic [TPR_W-1:0] TPR_RST = 17'h10000
) (
  input logic                clk,
  input logic                rst,
  input logic                post_vld,
  input logic [VEC_IN_W-1:0] post_vec,
  input logic                batch_vld,
  input logic [NVEC-1:0]     pend_bits,
  input logic [TPR_W-1:0]    tpr_q,
  input logic                pend_vld,
  input logic [VEC_W-1:0]    pend_vec,
  input logic                svc_vld,
  input logic [VEC_W-1:0]    svc_vec,
  input logic [1:0]          decision,
  input logic [5:0]          hint
);
  p_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (post_vld && post_vec[VEC_IN_W-1:VEC_W] != '0 && !batch_vld)
      |=> pend_bits == $past(pend_bits));

  p_no_loss_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend_bits & $past(pend_bits)) == $past(pend_bits));

  p_svc_nmi_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_vld && svc_vld && svc_vec == VEC_W'(2)) |-> decision == 2'd2);

  p_pend_nmi_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_vld && pend_vec == VEC_W'(2) && !(svc_vld && svc_vec == VEC_W'(2)))
      |-> decision == 2'd0);

  p_nmi_hint_r8: assert property (@(posedge clk) disable iff (rst)
    (pend_vld && pend_vec == VEC_W'(2)) |-> hint == 6'd32);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (tpr_q == TPR_RST && pend_bits == '0));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !pend_vld |-> (decision == 2'd0 && hint == 6'd0));

  p_code_r6: assert property (@(posedge clk) disable iff (rst)
    decision != 2'd3);
endmodule

bind irq_prio_mask irq_prio_mask_chk #(
  .VEC_IN_W(VEC_IN_W), .NVEC(NVEC), .VEC_W(VEC_W), .TPR_W(TPR_W), .TPR_RST(TPR_RST)
) u_chk (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_vec(post_vec),
  .batch_vld(batch_vld), .pend_bits(pend_bits), .tpr_q(tpr_q),
  .pend_vld(pend_vld), .pend_vec(pend_vec), .svc_vld(svc_vld),
  .svc_vec(svc_vec), .decision(decision), .hint(hint));

// File: tb/irq_prio_mask_tb.sv
module irq_prio_mask_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic post_vld = 0, batch_vld = 0, svc_ld = 0, tpr_wr = 0;
  logic [15:0] post_vec = '0;
  logic [NV-1:0] batch_bits = '0, svc_bits = '0;
  logic [16:0] tpr_data = '0;
  logic pend_vld, svc_vld, pend_invalid;
  logic [7:0] pend_vec, svc_vec;
  logic [1:0] decision;
  logic [5:0] hint;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NV-1:0] pend_m, svc_m;
  logic [16:0]   tpr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_mask u_dut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_vec(post_vec),
    .batch_vld(batch_vld), .batch_bits(batch_bits), .svc_ld(svc_ld),
    .svc_bits(svc_bits), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
    .pend_vld(pend_vld), .pend_vec(pend_vec), .svc_vld(svc_vld),
    .svc_vec(svc_vec), .decision(decision), .hint(hint),
    .pend_invalid(pend_invalid));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void top_of(input logic [NV-1:0] b, output bit f, output int v);
    f = 0; v = 0;
    if (b[2]) begin f = 1; v = 2; end
    else if (b[0]) begin f = 1; v = 0; end
    else for (int i = NV-1; i >= 0; i--) if (b[i]) begin f = 1; v = i; break; end
  endfunction

  function automatic int exp_dec(bit pf, int pv, bit sf, int sv, logic [16:0] t);
    bit ma = t[16];
    int mic = int'(t[7:4]);
    if (!pf) return 0;
    if (sf && sv == 2) return 2;
    if (pv == 2) return 0;
    if (sf && sv == 0) return 2;
    if (pv == 0) return ma ? 1 : 0;
    if (!sf || (pv/16) > (sv/16)) return (!ma && (pv/16) > mic) ? 0 : 1;
    return 2;
  endfunction

  function automatic int exp_hint(bit pf, int pv);
    if (!pf) return 0;
    if (pv == 2) return 32;
    if (pv == 0) return 16;
    return pv / 16;
  endfunction

  task automatic do_reset();
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    pend_m = '0; svc_m = '0; tpr_m = 17'h10000;
  endtask

  // drive for one edge, then wait for the registered outputs
  task automatic apply(bit pv, logic [15:0] vec, bit bv, logic [NV-1:0] bb,
                       bit sl, logic [NV-1:0] sb, bit tw, logic [16:0] td);
    post_vld = pv; post_vec = vec; batch_vld = bv; batch_bits = bb;
    svc_ld = sl; svc_bits = sb; tpr_wr = tw; tpr_data = td;
    if (pv && vec[15:8] == 0) pend_m[vec[7:0]] = 1'b1;
    if (bv) pend_m = pend_m | bb;
    if (sl) svc_m = sb;
    if (tw) tpr_m = td;
    @(negedge clk);
    post_vld = 0; batch_vld = 0; svc_ld = 0; tpr_wr = 0;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    bit pf, sf; int pv, sv;
    top_of(pend_m, pf, pv);
    top_of(svc_m, sf, sv);
    chk({tag, " R4 pend_vld"}, int'(pend_vld), int'(pf));
    if (pf) chk({tag, " R4 pend_vec"}, int'(pend_vec), pv);
    chk({tag, " R5 svc_vld"}, int'(svc_vld), int'(sf));
    if (sf) chk({tag, " R5 svc_vec"}, int'(svc_vec), sv);
    chk({tag, " R7 decision"}, int'(decision), exp_dec(pf, pv, sf, sv, tpr_m));
    chk({tag, " R8 hint"}, int'(hint), exp_hint(pf, pv));
    chk({tag, " R9 invalid"}, int'(pend_invalid),
        int'(pf && (pv == 1 || (pv >= 3 && pv <= 14))));
  endtask

  function automatic logic [NV-1:0] sparse(int n);
    logic [NV-1:0] b = '0;
    for (int k = 0; k < n; k++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) b[2] = 1'b1;
      else if (r == 1) b[0] = 1'b1;
      else if (r == 2) b[$urandom_range(1, 15)] = 1'b1;
      else b[$urandom_range(0, NV-1)] = 1'b1;
    end
    return b;
  endfunction

  function automatic logic [NV-1:0] one(int v);
    logic [NV-1:0] b = '0;
    b[v] = 1'b1;
    return b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    do_reset();
    @(negedge clk);
    // R10/R11: empty after reset
    chk("R10 pend_vld after reset", int'(pend_vld), 0);
    chk("R10 svc_vld after reset", int'(svc_vld), 0);
    chk("R11 decision idle", int'(decision), 0);
    chk("R11 hint idle", int'(hint), 0);

    // R2: out-of-range post ignored
    apply(1, 16'h0105, 0, '0, 0, '0, 0, '0);
    chk("R2 rejected post", int'(pend_vld), 0);

    // R1: single post, reset TPR masks it (R10)
    apply(1, 16'd77, 0, '0, 0, '0, 0, '0);
    chk("R1 posted vector", int'(pend_vec), 77);
    chk("R10 reset tpr masks", int'(decision), 1);
    check_all("R1");

    // R12: open TPR, class 3 -> vec 77 (class 4) deliverable
    apply(0, '0, 0, '0, 0, '0, 1, 17'h00030);
    chk("R12 tpr write deliver", int'(decision), 0);
    // R7: class equal to TPR class -> masked
    apply(0, '0, 0, '0, 0, '0, 1, 17'h00040);
    chk("R7 class not above tpr", int'(decision), 1);

    // R3: batch and post same cycle
    apply(1, 16'd130, 1, one(250) | one(40), 0, '0, 0, '0);
    chk("R3 batch wins high bit", int'(pend_vec), 250);
    apply(1, 16'd0, 1, one(251), 0, '0, 0, '0);
    chk("R3 post ext beats batch", int'(pend_vec), 0);
    chk("R8 ext hint", int'(hint), 16);
    chk("R6 ext with tpr open", int'(decision), 0);
    apply(1, 16'd2, 1, one(9), 0, '0, 0, '0);
    chk("R4 nmi precedence", int'(pend_vec), 2);
    chk("R8 nmi hint", int'(hint), 32);

    // R5/R6: in-service NMI masks even pending NMI
    apply(0, '0, 0, '0, 1, one(2) | one(200), 0, '0);
    chk("R5 svc nmi", int'(svc_vec), 2);
    chk("R6 svc nmi masks", int'(decision), 2);
    check_all("R6");

    // R6: ext pending with mask-all
    do_reset();
    apply(1, 16'd0, 0, '0, 0, '0, 1, 17'h10000);
    chk("R6 ext masked by mask-all", int'(decision), 1);
    apply(0, '0, 0, '0, 1, one(0), 0, '0);
    chk("R6 svc ext masks", int'(decision), 2);

    // R7: in-service same class -> masked by in-service
    do_reset();
    apply(1, 16'd100, 0, '0, 1, one(97), 1, 17'h0);
    chk("R7 same class svc mask", int'(decision), 2);
    // R9: reserved vector
    do_reset();
    apply(1, 16'd5, 0, '0, 0, '0, 0, '0);
    chk("R9 reserved flagged", int'(pend_invalid), 1);
    apply(1, 16'd15, 0, '0, 0, '0, 0, '0);
    chk("R9 vec15 not reserved", int'(pend_invalid), 0);

    // random mix
    for (int t = 0; t < 400; t++) begin
      do_reset();
      for (int s = 0; s < 4; s++) begin
        logic [15:0] v;
        logic [16:0] td;
        v = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(256, 65535))
                                        : 16'($urandom_range(0, 255));
        td = {($urandom_range(0, 3) == 0), 8'h0, 4'($urandom), 4'($urandom)};
        apply($urandom_range(0, 1) == 1, v, $urandom_range(0, 2) == 0,
              sparse($urandom_range(1, 3)), $urandom_range(0, 2) == 0,
              sparse($urandom_range(0, 2)), $urandom_range(0, 1) == 1, td);
        check_all("R3 R7 random");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule